// File: doc/BRIEF.md
# Truncating Configurable Approximate Multiplier

This block multiplies two unsigned operands and trades accuracy for power and delay under runtime control. A small level input selects how many low bits of each operand are discarded before the multiply. With level n, the low n bits of both operands are cleared and the shortened operands are multiplied. The true product then sits in the upper part of the result, and the lowest 2n result bits are always zero. The active partial-product array therefore shrinks as the level rises. Level 0 gives the exact product.

The result is captured in one register stage, so a result valid strobe follows the input strobe by one clock. The level is sampled together with the operands it applies to. A later change of level cannot alter a result that is already on its way to the output. The operand widths are parameters. The default is 32 by 32 bits, and a 32 by 8 variant is obtained by narrowing the second operand.

Top module: `trunc_approx_mul`

## Requirements
- R1: With level 0, the accepted product equals the exact unsigned product op_a * op_b.
- R2: With level n (0 to 4), the accepted product equals ((op_a >> n) * (op_b >> n)) << 2n.
- R3: For every accepted pair at level n, bits [2n-1:0] of prod are zero.
- R4: The level input is 3 bits wide. Values 5, 6 and 7 act exactly as level 4, which clears 8 result LSBs.
- R5: out_vld is high in the cycle after each clock edge where in_vld was high, and low otherwise. prod takes the new result in that same cycle.
- R6: While in_vld is low, prod keeps its last value, whatever op_a, op_b and lvl do.
- R7: The level sampled with an operand pair is the one applied to it. This holds when the level changes on every cycle of a back-to-back stream, and when it changes right after an acceptance.
- R8: During reset, out_vld and prod are zero. The asynchronous active-low reset is released synchronously, two clocks after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair and level are presented this cycle |
| op_a | input | A_W (32) | First unsigned operand |
| op_b | input | B_W (32) | Second unsigned operand |
| lvl | input | 3 | Approximation level, saturating at 4 |
| out_vld | output | 1 | prod holds a fresh result |
| prod | output | A_W+B_W (64) | Approximate product |

## Verification
Two things can land on the same clock edge. One is a new operand pair being accepted under a new level. The other is the previous result, computed under a different level, being replaced at the output. The bench provokes this by streaming pairs back to back while changing the level on every cycle across all eight codes. It also changes the level on the idle cycle that follows an acceptance. A behavioural model derives each expected product from the level sampled with its own pair, and the output is compared with it on every clock.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int LVL_W   = 3;
  localparam int MAX_LVL = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/tam_rst_sync.sv
module tam_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tam_level_sat.sv
module tam_level_sat
  import tam_pkg::*;
(
  input  lvl_t lvl_i,
  output lvl_t lvl_o
);
  localparam lvl_t LVL_CAP = lvl_t'(MAX_LVL);

  always_comb begin
    if (lvl_i > LVL_CAP) lvl_o = LVL_CAP;
    else                 lvl_o = lvl_i;
  end
endmodule

// File: rtl/tam_operand_trim.sv
module tam_operand_trim
  import tam_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  lvl_t         lvl_i,
  output logic [W-1:0] x_o
);
  // bit i survives only when its position is at or above the level
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned POS = i;
    assign x_o[i] = x_i[i] & (POS >= 32'(lvl_i));
  end
endmodule

// File: rtl/tam_pp_array.sv
module tam_pp_array #(
  parameter int A_W = 32,
  parameter int B_W = 32
) (
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] p_o
);
  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] row [B_W];

  // one partial-product row per multiplier bit; cleared bits gate rows off
  for (genvar r = 0; r < B_W; r++) begin : g_row
    assign row[r] = b_i[r] ? (P_W'(a_i) << r) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int r = 0; r < B_W; r++) begin
      p_o = p_o + row[r];
    end
  end
endmodule

// File: rtl/trunc_approx_mul.sv
module trunc_approx_mul
  import tam_pkg::*;
#(
  parameter int A_W = 32,
  parameter int B_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  input  logic [LVL_W-1:0]   lvl,
  output logic               out_vld,
  output logic [A_W+B_W-1:0] prod
);
  localparam int P_W = A_W + B_W;

  logic           rst_sync_n;
  lvl_t           lvl_sat;
  logic [A_W-1:0] a_trim;
  logic [B_W-1:0] b_trim;
  logic [P_W-1:0] pp_sum;

  logic [P_W-1:0] prod_q, prod_d;
  logic           vld_q, vld_d;

  tam_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tam_level_sat u_sat (
    .lvl_i (lvl),
    .lvl_o (lvl_sat)
  );

  tam_operand_trim #(.W(A_W)) u_trim_a (
    .x_i   (op_a),
    .lvl_i (lvl_sat),
    .x_o   (a_trim)
  );

  tam_operand_trim #(.W(B_W)) u_trim_b (
    .x_i   (op_b),
    .lvl_i (lvl_sat),
    .x_o   (b_trim)
  );

  tam_pp_array #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a_i (a_trim),
    .b_i (b_trim),
    .p_o (pp_sum)
  );

  // next state: capture only on an accepted pair
  always_comb begin
    vld_d  = in_vld;
    prod_d = in_vld ? pp_sum : prod_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign out_vld = vld_q;
  assign prod    = prod_q;
endmodule

// File: rtl/tam_checker.sv
module tam_checker #(
  parameter int A_W = 32,
  parameter int B_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_vld,
  input logic [2:0]         lvl,
  input logic [A_W-1:0]     op_a,
  input logic [B_W-1:0]     op_b,
  input logic               out_vld,
  input logic [A_W+B_W-1:0] prod
);
  localparam int P_W = A_W + B_W;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic int unsigned eff(input logic [2:0] l);
    return (l > 3'd4) ? 4 : int'(l);
  endfunction

  function automatic logic [P_W-1:0] low_mask(input logic [2:0] l);
    return (P_W'(1) << (2 * eff(l))) - P_W'(1);
  endfunction

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    in_vld |=> out_vld);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !in_vld |=> !out_vld);
  a_r1_exact: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (in_vld && lvl == 3'd0) |=> prod == (P_W'($past(op_a)) * P_W'($past(op_b))));
  a_r2_trunc_value: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    in_vld |=> prod == (((P_W'($past(op_a)) >> eff($past(lvl))) *
                         (P_W'($past(op_b)) >> eff($past(lvl)))) << (2 * eff($past(lvl)))));
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    in_vld |=> (prod & low_mask($past(lvl))) == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !in_vld |=> $stable(prod));
endmodule

bind trunc_approx_mul tam_checker #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .in_vld  (in_vld),
  .lvl     (lvl),
  .op_a    (op_a),
  .op_b    (op_b),
  .out_vld (out_vld),
  .prod    (prod)
);

// File: tb/trunc_approx_mul_tb_top.sv
`timescale 1ns/1ps
module trunc_approx_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] op_a, op_b;
  logic [2:0]  lvl;
  logic        out_vld;
  logic [63:0] prod;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  always #2.5 clk = ~clk;

  trunc_approx_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .lvl(lvl), .out_vld(out_vld), .prod(prod)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] l);
    int n = (l > 3'd4) ? 4 : int'(l);
    logic [63:0] sa = 64'(a) >> n;
    logic [63:0] sb = 64'(b) >> n;
    return (sa * sb) << (2 * n);
  endfunction

  // behavioural reference model, updated on every edge
  logic [63:0] exp_prod;
  logic        exp_vld;
  logic [2:0]  exp_lvl;
  string       exp_tag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_prod <= '0; exp_vld <= 1'b0; exp_lvl <= 3'd0; exp_tag <= "R8";
    end else begin
      exp_vld <= in_vld;
      if (in_vld) begin
        exp_prod <= ref_mul(op_a, op_b, lvl);
        exp_lvl  <= lvl;
        exp_tag  <= cur_tag;
      end else begin
        exp_tag <= "R6";
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare();
    int n;
    check("R5", 64'(out_vld), 64'(exp_vld));
    check(exp_tag, prod, exp_prod);
    if (exp_vld) begin
      n = (exp_lvl > 3'd4) ? 4 : int'(exp_lvl);
      check("R3", prod & ((64'd1 << (2 * n)) - 64'd1), 64'd0);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] l, input string tag);
    @(negedge clk);
    compare();
    in_vld = v; op_a = a; op_b = b; lvl = l; cur_tag = tag;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    rst_n = 1'b0; in_vld = 1'b0; op_a = 32'hffff_ffff; op_b = 32'hffff_ffff; lvl = 3'd0;
    repeat (3) @(negedge clk);
    check("R8", 64'(out_vld), 64'd0);
    check("R8", prod, 64'd0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 32'd0, 32'd0, 3'd0, "R6");

    // R1 exact products
    step(1'b1, 32'd0,          32'd0,          3'd0, "R1");
    step(1'b1, 32'hffff_ffff, 32'hffff_ffff,  3'd0, "R1");
    step(1'b1, 32'h1234_5678, 32'h9abc_def0,  3'd0, "R1");
    step(1'b1, 32'd1,          32'hffff_ffff,  3'd0, "R1");
    // R2 each level
    for (int l = 1; l <= 4; l++) begin
      step(1'b1, 32'hffff_ffff, 32'hffff_ffff, 3'(l), "R2");
      step(1'b1, 32'h0000_00ff, 32'h0000_000f, 3'(l), "R2");
      step(1'b1, 32'hdead_beef, 32'h0bad_f00d, 3'(l), "R2");
    end
    // R4 levels above the cap
    for (int l = 5; l <= 7; l++) begin
      step(1'b1, 32'hffff_ffff, 32'h8765_4321, 3'(l), "R4");
      step(1'b1, 32'h0000_01ff, 32'h0000_0100, 3'(l), "R4");
    end
    // R6 idle with moving inputs
    step(1'b0, 32'h5555_5555, 32'haaaa_aaaa, 3'd2, "R6");
    step(1'b0, 32'h0f0f_0f0f, 32'hf0f0_f0f0, 3'd7, "R6");
    step(1'b0, 32'h1111_1111, 32'h2222_2222, 3'd0, "R6");
    // R7 level change right after an acceptance
    step(1'b1, 32'hcafe_babe, 32'h1357_9bdf, 3'd0, "R7");
    step(1'b0, 32'hcafe_babe, 32'h1357_9bdf, 3'd4, "R7");
    step(1'b1, 32'hcafe_babe, 32'h1357_9bdf, 3'd4, "R7");
    step(1'b0, 32'hcafe_babe, 32'h1357_9bdf, 3'd0, "R7");
    // R7 back-to-back stream, level changes every cycle
    x = 32'h1ace_b00c;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a, b;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); a = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); b = x;
      step((k % 9) != 8, a, b, 3'(k % 8), "R7");
    end
    repeat (3) step(1'b0, 32'd0, 32'd0, 3'd0, "R6");
    finish_run();
  end
endmodule